// File: doc/BRIEF.md
# Stereo Serial Audio Transmit Serializer

This block turns pairs of stereo sample words into a single serial audio data line, most significant bit first. It does not make its own bit or frame clocks. An external clock generator supplies three inputs. The first is a one-cycle bit strobe, which marks the inactive bit-clock edge. The second is the channel select of the half-frame now running. The third is the index of the bit period inside that half-frame. Samples come in through a valid/ready handshake. A one-entry holding register keeps the next pair while the current pair is being shifted out.

Four configuration inputs shape each frame: the sample word length, the half-frame length, a right-justify bit and a delayed-MSB bit. Together they give standard I2S framing, left-justified framing or right-justified framing. The block reads the configuration only at a frame start, so a change never breaks a frame that is already on the line. Bit positions that carry no sample bit are driven low. When no new pair is waiting at a frame start, the previous pair is sent again and a sticky underrun flag is raised.

The controller is a three-state machine. IDLE means transmit is disabled; the line is low and the holder is empty. SYNC means transmit is enabled and the block is waiting for the first frame start. RUN means the block is serializing. The transitions are:
- IDLE to SYNC, named *arm*, when the enable is seen high.
- SYNC to RUN, named *lock*, on a frame start.
- SYNC or RUN to IDLE, named *drop*, when the enable is low.

Top module: `i2s_tx_serializer`

## Requirements
- R1: After reset, sd_out is 0, underrun is 0 and s_ready is 0 while tx_en is low.
- R2: The word-length code selects the bits taken from the low end of each 32-bit sample input: 0 gives 16 bits, 1 gives 24 bits, and 2 or 3 gives 32 bits.
- R3: The half-frame length code gives 16 (code 0), 32 (code 1) or 64 (codes 2 and 3) bit periods. A bit index at or beyond that length outputs 0.
- R4: With cfg_rjust=0 and cfg_i2s_dly=0, the word's MSB is sent at bit index 0 and the following bits come MSB-first. Bits that do not fit in the half-frame are dropped from the LSB end.
- R5: With cfg_rjust=0 and cfg_i2s_dly=1, the MSB is sent at bit index 1, one bit period after the frame edge, and index 0 outputs 0.
- R6: With cfg_rjust=1, the word's LSB is sent at the last bit index of the half-frame and cfg_i2s_dly has no effect. If the word is longer than the half-frame, its MSB-side bits are dropped.
- R7: Every bit position in a half-frame that carries no sample bit outputs 0.
- R8: frame_sel=0 carries the left word and frame_sel=1 carries the right word. A new pair is taken only at a frame start: a bit strobe with frame_sel=0 and bit_idx=0.
- R9: s_ready equals tx_en with the one-entry holder empty. A pair is accepted when s_valid and s_ready are both high at a clock edge.
- R10: If the holder is empty at a frame start, the previous pair is sent again and underrun goes to 1. It stays at 1 while tx_en remains high.
- R11: Configuration inputs are sampled only at a frame start and apply to the whole frame that follows.
- R12: When tx_en is low at a clock edge, sd_out and underrun are 0 after that edge and the holder is emptied. After tx_en rises, sd_out stays 0 until the first frame start that the block observes.
- R13: sd_out changes only in the cycle after a bit strobe, so it moves on the inactive bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| bit_tick | input | 1 | One-cycle strobe at the inactive bit-clock edge |
| frame_sel | input | 1 | Channel of the current half-frame (0 left, 1 right) |
| bit_idx | input | IDX_W (6) | Bit period index inside the half-frame |
| cfg_word_len | input | 2 | Word length code |
| cfg_half_len | input | 2 | Half-frame length code |
| cfg_rjust | input | 1 | Right-justify framing |
| cfg_i2s_dly | input | 1 | MSB one bit period after the frame edge |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Holder can take a pair |
| s_left | input | SAMPLE_W (32) | Left sample, LSB-aligned |
| s_right | input | SAMPLE_W (32) | Right sample, LSB-aligned |
| sd_out | output | 1 | Serial data line |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The embedded assertions check, on every cycle, the properties that hold in any situation:
- the quiet line, the cleared flag and the IDLE state after a low enable;
- that the line holds steady between strobes;
- that an accepted pair lands in the holder;
- that the underrun flag is sticky;
- that RUN is entered only on a frame start.

Whether each bit on the line is the right bit of the right word cannot be decided locally. Placement under every combination of word length, half-frame length and justification, truncation of long words, repetition of a starved pair, and the frame-boundary timing of configuration changes can only be shown by the bench. Its behavioural model rebuilds each half-frame from the requirements and compares the line, the flag and the handshake on every clock.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int SAMPLE_W = 32;
    localparam int MAX_HALF = 64;
    localparam int IDX_W    = $clog2(MAX_HALF);
    localparam int WB_W     = $clog2(SAMPLE_W) + 2;
    localparam int HB_W     = IDX_W + 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_RUN  = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [1:0] word_len;
        logic [1:0] half_len;
        logic       rjust;
        logic       late_msb;
    } tx_cfg_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } tx_pair_t;

    // Word length in bits for a code (code 3 behaves as 32)
    function automatic logic [WB_W-1:0] word_bits(input logic [1:0] code);
        logic [WB_W-1:0] r;
        case (code)
            2'd0:    r = WB_W'(16);
            2'd1:    r = WB_W'(24);
            default: r = WB_W'(32);
        endcase
        return r;
    endfunction

    // Half-frame length in bit periods for a code (code 3 behaves as 64)
    function automatic logic [HB_W-1:0] half_bits(input logic [1:0] code);
        logic [HB_W-1:0] r;
        case (code)
            2'd0:    r = HB_W'(16);
            2'd1:    r = HB_W'(32);
            default: r = HB_W'(64);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
    import i2s_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic bit_tick,
    input  logic frame_start,
    output logic load_frame,
    output logic emit,
    output logic blank
);

    tx_state_e state_q;
    tx_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: arm, lock, drop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (tx_en) state_d = ST_SYNC;
            ST_SYNC: begin
                if (!tx_en)           state_d = ST_IDLE;
                else if (frame_start) state_d = ST_RUN;
            end
            ST_RUN:  if (!tx_en) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        load_frame = 1'b0;
        emit       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_frame = 1'b0;
                emit       = 1'b0;
            end
            ST_SYNC: begin
                load_frame = tx_en && frame_start;
                emit       = tx_en && frame_start && bit_tick;
            end
            ST_RUN: begin
                load_frame = tx_en && frame_start;
                emit       = tx_en && bit_tick;
            end
            default: begin
                load_frame = 1'b0;
                emit       = 1'b0;
            end
        endcase
        blank = !tx_en || (bit_tick && !emit);
    end

    p_off_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (state_q == ST_IDLE));

    p_run_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_RUN) |-> $past(frame_start));

endmodule

// File: rtl/i2s_tx_pair_buf.sv
module i2s_tx_pair_buf
    import i2s_tx_pkg::*;
#(
    parameter int WORD_W = SAMPLE_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              load_frame,
    input  logic              s_valid,
    input  logic [WORD_W-1:0] s_left,
    input  logic [WORD_W-1:0] s_right,
    output logic              s_ready,
    output logic [WORD_W-1:0] use_left,
    output logic [WORD_W-1:0] use_right,
    output logic              underrun
);

    logic [WORD_W-1:0] pend_l, pend_r, cur_l, cur_r;
    logic              pend_valid;

    assign s_ready = tx_en && !pend_valid;

    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            pend_l     <= '0;
            pend_r     <= '0;
            cur_l      <= '0;
            cur_r      <= '0;
            pend_valid <= 1'b0;
            underrun   <= 1'b0;
        end else begin
            if (load_frame) begin
                if (pend_valid) begin
                    cur_l      <= pend_l;
                    cur_r      <= pend_r;
                    pend_valid <= 1'b0;
                end else begin
                    underrun   <= 1'b1;
                end
            end
            if (s_valid && s_ready) begin
                pend_l     <= s_left;
                pend_r     <= s_right;
                pend_valid <= 1'b1;
            end
        end
    end

    // The pair of the frame starting now is visible in the same cycle
    always_comb begin
        if (load_frame && pend_valid) begin
            use_left  = pend_l;
            use_right = pend_r;
        end else begin
            use_left  = cur_l;
            use_right = cur_r;
        end
    end

    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> pend_valid);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && tx_en) |=> underrun);

    p_clear_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !underrun);

endmodule

// File: rtl/i2s_tx_slot_map.sv
module i2s_tx_slot_map
    import i2s_tx_pkg::*;
#(
    parameter int WORD_W = SAMPLE_W,
    parameter int IW     = IDX_W
)(
    input  tx_cfg_t           cfg,
    input  logic [WORD_W-1:0] word,
    input  logic [IW-1:0]     idx,
    output logic              bit_val
);

    localparam int SW = IW + 4;

    logic [WB_W-1:0]      wbits;
    logic [HB_W-1:0]      hbits;
    logic signed [SW-1:0] wb_s, hb_s, idx_s, start_s, sel_s;
    logic                 in_word;

    always_comb begin
        wbits = word_bits(cfg.word_len);
        hbits = half_bits(cfg.half_len);
        wb_s  = $signed(SW'(wbits));
        hb_s  = $signed(SW'(hbits));
        idx_s = $signed(SW'(idx));
        // First bit position of the word inside the half-frame
        if (cfg.rjust)         start_s = hb_s - wb_s;
        else if (cfg.late_msb) start_s = SW'(1);
        else                   start_s = '0;
        // Word bit number carried at this position
        sel_s   = wb_s - SW'(1) - (idx_s - start_s);
        in_word = (sel_s >= 0) && (sel_s < wb_s) && (idx_s < hb_s);
        bit_val = in_word ? word[sel_s[$clog2(WORD_W)-1:0]] : 1'b0;
    end

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
    import i2s_tx_pkg::*;
#(
    parameter int SAMPLE_WIDTH = SAMPLE_W,
    parameter int IDX_WIDTH    = IDX_W
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tx_en,
    input  logic                    bit_tick,
    input  logic                    frame_sel,
    input  logic [IDX_WIDTH-1:0]    bit_idx,
    input  logic [1:0]              cfg_word_len,
    input  logic [1:0]              cfg_half_len,
    input  logic                    cfg_rjust,
    input  logic                    cfg_i2s_dly,
    input  logic                    s_valid,
    output logic                    s_ready,
    input  logic [SAMPLE_WIDTH-1:0] s_left,
    input  logic [SAMPLE_WIDTH-1:0] s_right,
    output logic                    sd_out,
    output logic                    underrun
);

    logic                    frame_start, load_frame, emit, blank, bit_val;
    logic [SAMPLE_WIDTH-1:0] use_left, use_right, word;
    tx_cfg_t                 cfg_in, cfg_q, cfg_use;

    assign frame_start = bit_tick && !frame_sel && (bit_idx == '0);
    assign cfg_in      = '{word_len: cfg_word_len, half_len: cfg_half_len,
                           rjust: cfg_rjust, late_msb: cfg_i2s_dly};

    i2s_tx_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .bit_tick    (bit_tick),
        .frame_start (frame_start),
        .load_frame  (load_frame),
        .emit        (emit),
        .blank       (blank)
    );

    i2s_tx_pair_buf #(.WORD_W(SAMPLE_WIDTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .load_frame (load_frame),
        .s_valid    (s_valid),
        .s_left     (s_left),
        .s_right    (s_right),
        .s_ready    (s_ready),
        .use_left   (use_left),
        .use_right  (use_right),
        .underrun   (underrun)
    );

    // Configuration snapshot taken at each frame start
    always_ff @(posedge clk) begin
        if (!rst_n)          cfg_q <= '0;
        else if (load_frame) cfg_q <= cfg_in;
    end

    assign cfg_use = load_frame ? cfg_in : cfg_q;
    assign word    = frame_sel ? use_right : use_left;

    i2s_tx_slot_map #(.WORD_W(SAMPLE_WIDTH), .IW(IDX_WIDTH)) u_map (
        .cfg     (cfg_use),
        .word    (word),
        .idx     (bit_idx),
        .bit_val (bit_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)    sd_out <= 1'b0;
        else if (blank) sd_out <= 1'b0;
        else if (emit)  sd_out <= bit_val;
    end

    p_quiet_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !sd_out);

    p_hold_between_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !bit_tick) |=> $stable(sd_out));

endmodule

// File: tb/i2s_tx_serializer_tb.sv
`timescale 1ns/1ps
module i2s_tx_serializer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic        bit_tick = 1'b0;
    logic        frame_sel = 1'b0;
    logic [5:0]  bit_idx = '0;
    logic [1:0]  cfg_word_len = 2'd0;
    logic [1:0]  cfg_half_len = 2'd0;
    logic        cfg_rjust = 1'b0;
    logic        cfg_i2s_dly = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [31:0] s_left = '0;
    logic [31:0] s_right = '0;
    logic        sd_out;
    logic        underrun;

    int  n_checks = 0;
    int  n_bad = 0;
    bit  done = 0;
    bit  feed_on = 0;

    always #2 clk = ~clk;

    i2s_tx_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick),
        .frame_sel(frame_sel), .bit_idx(bit_idx),
        .cfg_word_len(cfg_word_len), .cfg_half_len(cfg_half_len),
        .cfg_rjust(cfg_rjust), .cfg_i2s_dly(cfg_i2s_dly),
        .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
        .sd_out(sd_out), .underrun(underrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Clock generator model: strobe every 4 cycles
    int gdiv = 0;
    int gpos = 0;
    int gen_h = 16;
    always @(negedge clk) begin
        if (gdiv == 3) begin
            gdiv = 0;
            bit_tick  <= 1'b1;
            frame_sel <= (gpos >= gen_h);
            bit_idx   <= 6'((gpos >= gen_h) ? gpos - gen_h : gpos);
            gpos = (gpos + 1 >= 2 * gen_h) ? 0 : gpos + 1;
        end else begin
            gdiv++;
            bit_tick <= 1'b0;
        end
    end

    // Behavioural reference model
    logic        m_arr [2][64];
    logic [31:0] m_pl, m_pr, m_cl, m_cr;
    bit          m_pend, m_armed, m_synced, m_under, m_acc;
    logic        exp_sd = 1'b0;
    string       m_mode = "R12";

    task automatic build_frame();
        int w, h, st;
        logic [31:0] wd;
        w  = (cfg_word_len == 0) ? 16 : (cfg_word_len == 1) ? 24 : 32;
        h  = (cfg_half_len == 0) ? 16 : (cfg_half_len == 1) ? 32 : 64;
        st = cfg_rjust ? h - w : (cfg_i2s_dly ? 1 : 0);
        m_mode = cfg_rjust ? "R6" : (cfg_i2s_dly ? "R5" : "R4");
        for (int c = 0; c < 2; c++) begin
            wd = (c == 0) ? m_cl : m_cr;
            for (int p = 0; p < 64; p++) m_arr[c][p] = 1'b0;
            for (int k = 0; k < w; k++)
                if (st + k >= 0 && st + k < h) m_arr[c][st + k] = wd[w - 1 - k];
        end
    endtask

    always @(posedge clk) begin
        bit fs, pre;
        fs = bit_tick && !frame_sel && bit_idx == 0;
        if (fs) gen_h = (cfg_half_len == 0) ? 16 : (cfg_half_len == 1) ? 32 : 64;
        if (!rst_n || !tx_en) begin
            exp_sd = 0; m_pend = 0; m_under = 0; m_armed = 0; m_synced = 0;
            m_cl = 0; m_cr = 0; m_acc = 0; m_mode = "R12";
        end else begin
            pre = m_pend;
            if (!m_armed) begin
                m_armed = 1;
                if (bit_tick) exp_sd = 0;
            end else begin
                if (fs) begin
                    if (m_pend) begin m_cl = m_pl; m_cr = m_pr; m_pend = 0; end
                    else m_under = 1;
                    build_frame();
                    m_synced = 1;
                end
                if (bit_tick) exp_sd = m_synced ? m_arr[frame_sel][bit_idx] : 1'b0;
            end
            if (s_valid && !pre) begin
                m_pl = s_left; m_pr = s_right; m_pend = 1; m_acc = 1;
            end
        end
    end

    // Per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk($sformatf("sd_out %s (R2 R3 R7 R8 R11 R13)", m_mode), 32'(sd_out), 32'(exp_sd));
            chk("underrun R10", 32'(underrun), 32'(m_under));
            chk("s_ready R9", 32'(s_ready), 32'(tx_en && !m_pend));
        end
    end

    // Sample producer
    always @(negedge clk) begin
        if (m_acc) begin
            m_acc = 0;
            s_left  <= $urandom;
            s_right <= $urandom;
        end
        s_valid <= feed_on;
    end

    task automatic set_cfg(input int wl, input int hl, input bit rj, input bit dl);
        @(negedge clk);
        cfg_word_len = 2'(wl); cfg_half_len = 2'(hl);
        cfg_rjust = rj; cfg_i2s_dly = dl;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        s_left = $urandom; s_right = $urandom;
        wait_cyc(6);
        chk("reset sd_out R1", 32'(sd_out), 0);
        chk("reset underrun R1", 32'(underrun), 0);
        chk("reset s_ready R1", 32'(s_ready), 0);
        rst_n = 1'b1;
        wait_cyc(3);
        chk("disabled s_ready R1", 32'(s_ready), 0);
        feed_on = 1;
        tx_en = 1'b1;
        // R4 left-justified 16 in 16
        wait_cyc(600);
        set_cfg(1, 1, 0, 1);   // R5 I2S delay, 24 in 32
        wait_cyc(900);
        set_cfg(1, 1, 1, 0);   // R6 right-justified 24 in 32
        wait_cyc(777);
        set_cfg(2, 2, 1, 1);   // R6 32 in 64, delay ignored
        wait_cyc(1500);
        set_cfg(2, 0, 1, 0);   // R6 truncation 32 in 16
        wait_cyc(650);
        set_cfg(2, 0, 0, 1);   // R5 truncation with delay
        wait_cyc(500);
        set_cfg(0, 3, 0, 0);   // R2 R3 codes, R7 zero fill
        wait_cyc(1300);
        set_cfg(3, 1, 0, 0);   // R2 code 3
        wait_cyc(700);
        // R10 starvation
        feed_on = 0;
        wait_cyc(1000);
        chk("underrun after starvation R10", 32'(underrun), 1);
        feed_on = 1;
        wait_cyc(500);
        chk("underrun sticky R10", 32'(underrun), 1);
        // R12 disable
        tx_en = 1'b0;
        wait_cyc(5);
        chk("underrun cleared R12", 32'(underrun), 0);
        chk("line quiet R12", 32'(sd_out), 0);
        chk("ready low off R12", 32'(s_ready), 0);
        tx_en = 1'b1;
        set_cfg(0, 0, 1, 0);   // R11 change lands at next frame
        wait_cyc(900);
        set_cfg(1, 2, 0, 1);
        wait_cyc(1200);
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule